// File: doc/BRIEF.md
# Polyphase Decimate-by-20 FIR Filter

This block is a real-valued low-pass FIR filter that lowers the sample rate by a fixed factor, twenty by default. Outputs that decimation would throw away are never computed. Every accepted input sample is multiplied only by the sub-filter of its phase within the current twenty-sample frame. That sub-filter holds one coefficient out of every twenty. The products are added into a running frame sum. When the last sample of a frame arrives, the frame sum is exactly the full-rate filter output at that sample. It is then rounded, saturated and presented as one decimated output.

The prototype coefficients are a build-time parameter. If their count is not a multiple of the decimation factor, the missing upper taps act as zeros. Input samples are accepted on cycles where the input valid is high, and idle cycles have no effect. A synchronous active-low reset clears the sample history, the frame sum and the phase. The prototype must be longer than one frame (more than DECIM taps).

Top module: `polyphase_decim`

## Requirements
- R1: While reset is held and afterwards, out_valid stays low until exactly DECIM valid inputs have been accepted. The first out_valid pulse comes in the cycle after the clock edge that accepts the DECIM-th input.
- R2: out_valid is a one-cycle pulse. Exactly one is produced for every DECIM accepted inputs, so a gap-free input stream yields pulses spaced DECIM cycles apart.
- R3: On a cycle with in_valid low, in_data is ignored. The phase, the sample history and the frame sum do not change, so later outputs are the same as those of the same stream without the idle cycles.
- R4: Let x[j] be the accepted inputs counted from 0 after reset, and h[k] the prototype coefficients. Output number m equals round(sum over k of h[k]*x[n-k]) at n = DECIM*m + DECIM-1. Terms with n-k < 0 are zero.
- R5: An input at offset r within its frame (r = 0 for the first sample of a frame) meets coefficient h[DECIM-1-r + DECIM*i] in output m+i, where m is the output of its own frame.
- R6: Coefficient indices at or above NTAPS, up to the next multiple of DECIM, contribute zero.
- R7: The rounded value is clipped to the signed OUT_W range: at most 2^(OUT_W-1)-1 and at least -2^(OUT_W-1).
- R8: A synchronous reset in the middle of a frame discards all history and the partial frame. The next output again needs DECIM fresh inputs and depends only on them.
- R9: Rounding is half-up on the Q(COEF_W-1) scaled sum: out = floor((sum + 2^(COEF_W-2)) / 2^(COEF_W-1)), before clipping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | High when in_data carries a sample |
| in_data | input | IN_W | Signed input sample |
| out_valid | output | 1 | One-cycle pulse marking a decimated output |
| out_data | output | OUT_W | Signed, rounded and saturated filter output |

## Verification
Several properties are checked on every cycle by the assertions. The phase never leaves its range and wraps to zero after the last slot. Phase and sample history stay frozen through idle cycles. A pulse follows only an accepted last-of-frame input and never lasts two cycles. Reset leaves phase zero with no pulse. The numeric behaviour can only be shown by the bench scenarios: the match with a full-rate filter followed by decimation, the phase-to-coefficient mapping seen in impulse responses, zero padding, half-up rounding and clipping.

// File: rtl/dec_pkg.sv
// Shared helpers for the polyphase decimator.
// Assumes: arguments are positive compile-time constants.
package dec_pkg;

    // Integer division rounded upward.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/dec_phase_ctr.sv
// Modulo-DECIM counter giving the phase (offset within the frame) of the
// sample currently offered. It advances only on accepted samples.
// Assumes: DECIM >= 2.
module dec_phase_ctr #(
    parameter int DECIM = 20,
    parameter int PW    = $clog2(DECIM)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic [PW-1:0] phase,
    output logic          frame_end
);
    localparam logic [PW-1:0] LAST = PW'(DECIM - 1);

    assign frame_end = (phase == LAST);

    // Count accepted samples, wrapping at the end of each frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (in_valid)
            phase <= frame_end ? '0 : phase + 1'b1;
    end

    assert_phase_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= LAST);
    assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && frame_end) |=> (phase == '0));
    assert_phase_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(phase));
endmodule

// File: rtl/dec_tap_line.sv
// Sample history for the polyphase filter. Holds the last DECIM*(TPP-1)
// accepted samples and exposes only those whose distance from the incoming
// sample is a multiple of DECIM, since those are the only ones any phase uses.
// Assumes: TPP >= 2.
module dec_tap_line #(
    parameter int IN_W  = 16,
    parameter int DECIM = 20,
    parameter int TPP   = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      shift_en,
    input  logic signed [IN_W-1:0]    din,
    output logic [(TPP-1)*IN_W-1:0]   hist_flat
);
    localparam int LEN = DECIM * (TPP - 1);

    logic signed [IN_W-1:0] line [LEN];

    // Shift in accepted samples; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < LEN; j++) line[j] <= '0;
        end else if (shift_en) begin
            line[0] <= din;
            for (int j = 1; j < LEN; j++) line[j] <= line[j-1];
        end
    end

    for (genvar i = 1; i < TPP; i++) begin : g_out
        assign hist_flat[(i-1)*IN_W +: IN_W] = line[DECIM*i - 1];
    end
endmodule

// File: rtl/dec_phase_mac.sv
// Sub-filter of the current phase: TPP multiplies and an adder chain.
// Phase r, tap i uses prototype index DECIM-1-r + DECIM*i; indices at or
// beyond NTAPS are padding and read as zero.
// Assumes: phase < DECIM.
module dec_phase_mac #(
    parameter int IN_W   = 16,
    parameter int COEF_W = 16,
    parameter int DECIM  = 20,
    parameter int PW     = $clog2(DECIM),
    parameter int TPP    = 5,
    parameter int NTAPS  = 100,
    parameter int SUM_W  = 39,
    parameter logic [NTAPS*COEF_W-1:0] COEF_FLAT = '0
) (
    input  logic signed [IN_W-1:0]   din,
    input  logic [(TPP-1)*IN_W-1:0]  hist_flat,
    input  logic [PW-1:0]            phase,
    output logic signed [SUM_W-1:0]  partial
);
    localparam int PROD_W = IN_W + COEF_W;

    logic signed [COEF_W-1:0] coef_tab [TPP][DECIM];
    logic signed [IN_W-1:0]   samp     [TPP];
    logic signed [PROD_W-1:0] prod     [TPP];

    assign samp[0] = din;
    for (genvar i = 1; i < TPP; i++) begin : g_samp
        assign samp[i] = hist_flat[(i-1)*IN_W +: IN_W];
    end

    for (genvar i = 0; i < TPP; i++) begin : g_tap
        for (genvar r = 0; r < DECIM; r++) begin : g_ph
            localparam int CIDX = DECIM - 1 - r + DECIM * i;
            if (CIDX < NTAPS) begin : g_real
                assign coef_tab[i][r] = COEF_FLAT[CIDX*COEF_W +: COEF_W];
            end else begin : g_pad
                assign coef_tab[i][r] = '0;
            end
        end
        assign prod[i] = samp[i] * coef_tab[i][phase];
    end

    // Sum the phase products at full accumulator width.
    always_comb begin
        partial = '0;
        for (int i = 0; i < TPP; i++) partial = partial + SUM_W'(prod[i]);
    end
endmodule

// File: rtl/dec_out_stage.sv
// Frame accumulator and output conditioning. Adds each phase partial sum;
// on the last sample of a frame it rounds half-up, drops SHIFT fraction
// bits, clips to OUT_W and issues a one-cycle valid.
// Assumes: ACC_W is wide enough for the full frame sum.
module dec_out_stage #(
    parameter int ACC_W = 39,
    parameter int OUT_W = 16,
    parameter int SHIFT = 15
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_fire,
    input  logic                     frame_end,
    input  logic signed [ACC_W-1:0]  partial,
    output logic                     out_valid,
    output logic signed [OUT_W-1:0]  out_data
);
    localparam logic signed [ACC_W:0] HALF    = (ACC_W+1)'(1) <<< (SHIFT - 1);
    localparam logic signed [ACC_W:0] OUT_MAX = (ACC_W+1)'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [ACC_W:0] OUT_MIN = -OUT_MAX - (ACC_W+1)'(1);

    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] total;
    logic signed [ACC_W:0]   biased;
    logic signed [ACC_W:0]   scaled;
    logic signed [OUT_W-1:0] clipped;

    assign total  = acc + partial;
    assign biased = (ACC_W+1)'(total) + HALF;
    assign scaled = biased >>> SHIFT;

    // Clip the rounded value to the output range.
    always_comb begin
        if (scaled > OUT_MAX)      clipped = OUT_MAX[OUT_W-1:0];
        else if (scaled < OUT_MIN) clipped = OUT_MIN[OUT_W-1:0];
        else                       clipped = scaled[OUT_W-1:0];
    end

    // Accumulate within a frame; restart from zero after the last phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (in_fire)
            acc <= frame_end ? '0 : total;
    end

    // Register the finished output and its one-cycle valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_fire && frame_end;
            if (in_fire && frame_end) out_data <= clipped;
        end
    end

    assert_valid_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_fire && frame_end));
    assert_acc_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_fire |=> $stable(acc));
endmodule

// File: rtl/polyphase_decim.sv
// Polyphase decimate-by-DECIM FIR. Each accepted sample costs TPP
// multiplies; only retained outputs are formed.
// Assumes: NTAPS > DECIM, DECIM >= 2, OUT_W <= 31.
module polyphase_decim #(
    parameter int DECIM  = 20,
    parameter int NTAPS  = 100,
    parameter int IN_W   = 16,
    parameter int COEF_W = 16,
    parameter int OUT_W  = 16,
    parameter logic [NTAPS*COEF_W-1:0] COEF_FLAT = {NTAPS{COEF_W'(2 ** (COEF_W - 8))}}
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_data,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_data
);
    localparam int PAD   = dec_pkg::ceil_div(NTAPS, DECIM) * DECIM;
    localparam int TPP   = PAD / DECIM;
    localparam int PW    = $clog2(DECIM);
    localparam int ACC_W = IN_W + COEF_W + $clog2(PAD);
    localparam int SHIFT = COEF_W - 1;

    logic [PW-1:0]              phase;
    logic                       frame_end;
    logic [(TPP-1)*IN_W-1:0]    hist_flat;
    logic signed [ACC_W-1:0]    partial;

    dec_phase_ctr #(.DECIM(DECIM), .PW(PW)) u_ctr (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .phase(phase), .frame_end(frame_end)
    );

    dec_tap_line #(.IN_W(IN_W), .DECIM(DECIM), .TPP(TPP)) u_line (
        .clk(clk), .rst_n(rst_n), .shift_en(in_valid),
        .din(in_data), .hist_flat(hist_flat)
    );

    dec_phase_mac #(
        .IN_W(IN_W), .COEF_W(COEF_W), .DECIM(DECIM), .PW(PW), .TPP(TPP),
        .NTAPS(NTAPS), .SUM_W(ACC_W), .COEF_FLAT(COEF_FLAT)
    ) u_mac (
        .din(in_data), .hist_flat(hist_flat), .phase(phase), .partial(partial)
    );

    dec_out_stage #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SHIFT(SHIFT)) u_out (
        .clk(clk), .rst_n(rst_n), .in_fire(in_valid), .frame_end(frame_end),
        .partial(partial), .out_valid(out_valid), .out_data(out_data)
    );

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    assert_history_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(hist_flat));
    assert_reset_clear_R8: assert property (@(posedge clk)
        !rst_n |=> (phase == '0 && !out_valid));
endmodule

// File: tb/tb_polyphase_decim.sv
module tb_polyphase_decim;
    localparam int CLK_PERIOD = 10;
    localparam int DECIM  = 20;
    localparam int NTAPS  = 90;
    localparam int IN_W   = 16;
    localparam int COEF_W = 16;
    localparam int OUT_W  = 12;

    function automatic int coef_val(input int k);
        return ((k * 37) % 97) - 20;
    endfunction

    function automatic logic [NTAPS*COEF_W-1:0] pack_coefs();
        logic [NTAPS*COEF_W-1:0] v;
        v = '0;
        for (int k = 0; k < NTAPS; k++) v[k*COEF_W +: COEF_W] = COEF_W'(coef_val(k));
        return v;
    endfunction

    localparam logic [NTAPS*COEF_W-1:0] TB_COEFS = pack_coefs();

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [IN_W-1:0] in_data = '0;
    logic out_valid;
    logic signed [OUT_W-1:0] out_data;

    polyphase_decim #(
        .DECIM(DECIM), .NTAPS(NTAPS), .IN_W(IN_W), .COEF_W(COEF_W),
        .OUT_W(OUT_W), .COEF_FLAT(TB_COEFS)
    ) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycle = 0;
    bit done = 0;
    longint hist[$];
    longint exp_q[$];
    longint got_q[$];
    int stamp_q[$];
    int n_in = 0;
    logic [15:0] lfsr = 16'hACE1;

    always @(posedge clk) cycle <= cycle + 1;

    // Collect outputs away from the active edge.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            got_q.push_back(longint'(out_data));
            stamp_q.push_back(cycle);
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint round_clip(input longint s);
        longint q;
        longint hi;
        hi = (longint'(1) << (OUT_W - 1)) - 1;
        q = (s + (longint'(1) << (COEF_W - 2))) >>> (COEF_W - 1);
        if (q > hi) q = hi;
        if (q < -hi - 1) q = -hi - 1;
        return q;
    endfunction

    task automatic push(input int x);
        longint s;
        @(negedge clk);
        in_valid = 1'b1;
        in_data = IN_W'(x);
        hist.push_front(longint'(x));
        if (hist.size() > NTAPS) void'(hist.pop_back());
        n_in++;
        if (n_in % DECIM == 0) begin
            s = 0;
            for (int k = 0; k < hist.size(); k++) s += longint'(coef_val(k)) * hist[k];
            exp_q.push_back(round_clip(s));
        end
    endtask

    task automatic idle(input int n, input bit garbage);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data = garbage ? IN_W'(16'h7A5C ^ i) : '0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid during reset", longint'(out_valid), 0);
        rst_n = 1'b1;
        hist.delete(); exp_q.delete(); got_q.delete(); stamp_q.delete();
        n_in = 0;
    endtask

    task automatic compare_all(input string req);
        idle(3, 1'b0);
        chk(got_q.size() == exp_q.size(), {req, " output count"}, got_q.size(), exp_q.size());
        for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
            chk(got_q[i] == exp_q[i], {req, " output value"}, got_q[i], exp_q[i]);
        got_q.delete(); exp_q.delete(); stamp_q.delete();
    endtask

    function automatic int next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return int'($signed(lfsr[12:0]));
    endfunction

    // R1: first output after exactly DECIM inputs.
    task automatic t_first_output();
        do_reset();
        for (int i = 0; i < DECIM - 1; i++) push(1000 + i);
        idle(3, 1'b0);
        chk(got_q.size() == 0, "R1 no output before frame full", got_q.size(), 0);
        push(500);
        @(negedge clk);
        chk(out_valid == 1'b1, "R1 pulse after DECIM-th input", longint'(out_valid), 1);
        compare_all("R1");
    endtask

    // R2/R4: continuous pseudo-random stream against full-rate reference.
    task automatic t_stream();
        do_reset();
        for (int i = 0; i < 20 * DECIM; i++) push(next_rand());
        idle(3, 1'b0);
        for (int i = 1; i < stamp_q.size(); i++)
            chk(stamp_q[i] - stamp_q[i-1] == DECIM, "R2 pulse spacing",
                stamp_q[i] - stamp_q[i-1], DECIM);
        chk(stamp_q.size() == 20, "R2 one pulse per frame", stamp_q.size(), 20);
        compare_all("R4");
    endtask

    // R3: idle cycles with garbage data change nothing.
    task automatic t_gaps();
        do_reset();
        for (int i = 0; i < 8 * DECIM; i++) begin
            push(next_rand());
            if (i % 3 == 1) idle(1 + (i % 4), 1'b1);
        end
        compare_all("R3");
    endtask

    // R5/R6/R9: impulse responses per phase offset.
    task automatic t_impulse(input int r);
        int k;
        longint e;
        do_reset();
        for (int i = 0; i < 5 * DECIM; i++) push(i == r ? 16384 : 0);
        idle(3, 1'b0);
        chk(got_q.size() == 5, "R5 impulse output count", got_q.size(), 5);
        for (int m = 0; m < 5 && m < got_q.size(); m++) begin
            k = DECIM - 1 - r + DECIM * m;
            e = (k < NTAPS) ? ((longint'(coef_val(k)) * 16384 + 16384) >>> 15) : 0;
            if (k >= NTAPS) chk(got_q[m] == e, "R6 padded tap reads zero", got_q[m], e);
            else            chk(got_q[m] == e, "R5 R9 phase tap rounded", got_q[m], e);
        end
        got_q.delete(); exp_q.delete(); stamp_q.delete();
    endtask

    // R7: saturation at both ends.
    task automatic t_saturate();
        do_reset();
        for (int i = 0; i < 5 * DECIM; i++) push(32767);
        for (int i = 0; i < 5 * DECIM; i++) push(-32768);
        idle(3, 1'b0);
        if (got_q.size() == 10) begin
            chk(got_q[4] == 2047, "R7 positive clip", got_q[4], 2047);
            chk(got_q[9] == -2048, "R7 negative clip", got_q[9], -2048);
        end else begin
            chk(1'b0, "R7 output count", got_q.size(), 10);
        end
        compare_all("R7");
    endtask

    // R8: reset mid-frame discards history and phase.
    task automatic t_mid_reset();
        do_reset();
        for (int i = 0; i < 13; i++) push(9000 - i * 50);
        idle(1, 1'b0);
        do_reset();
        for (int i = 0; i < DECIM - 1; i++) push(1000);
        idle(2, 1'b0);
        chk(got_q.size() == 0, "R8 phase restarted", got_q.size(), 0);
        for (int i = 0; i < 2 * DECIM + 1; i++) push(1000);
        compare_all("R8");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycle, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_first_output();
        t_stream();
        t_gaps();
        t_impulse(0);
        t_impulse(7);
        t_impulse(19);
        t_saturate();
        t_mid_reset();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule